// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Front End

This block is the bus-facing half of a 256-byte two-wire (I2C) serial EEPROM. It oversamples SCL and SDA with the core clock and finds START and STOP conditions. It then runs a bit and byte sequencer that takes in the device address, the R/W bit, the byte address and any write data. It answers on SDA through an open-drain pull-down enable, so `sda_oe` high means SDA is pulled low.

The storage array and the page write buffer sit outside the block. Reads present `rd_addr` and take `rd_data` back combinationally in the same clock. Each accepted write byte leaves on a one-cycle `wr_en` strobe, with its address and data. A STOP that ends a write with at least one accepted byte raises `wr_commit`, and that starts the external programming cycle. The external programmer reports that cycle on `busy_i`. A `wp_i` input blocks all programming.

One address counter persists across transactions and always points one past the last byte read or written. Current-address reads use it directly. Selective reads reload it with a dummy write. Sequential reads step it across the whole array, while page writes step only its low four bits.

Top module: `i2c_ee_slave`

## Requirements
- R1: A falling SDA while SCL is high is a START and puts the sequencer into device-address reception, even in the middle of a byte. A rising SDA while SCL is high is a STOP and returns it to idle. After reset, `sda_oe`, `wr_en` and `wr_commit` are low.
- R2: The first byte after START carries a 7-bit device address, MSB first, followed by R/W (1 = read). Only address 7'h50 (parameter) is acknowledged, by pulling SDA low during the 9th clock. Any other address gets no acknowledge, and the slave ignores all later bytes until the next START.
- R3: While `busy_i` is high, a matching device address is not acknowledged, whatever the R/W bit. Once `busy_i` is low again, it is acknowledged.
- R4: In a write, the byte after the device address is acknowledged and loaded into the address counter.
- R5: Each data byte in a write is acknowledged and forwarded as a one-cycle `wr_en`, with `wr_addr` equal to the counter and `wr_data` equal to the byte. The counter's low 4 bits then increment and wrap within the 16-byte page, and bits 7:4 are unchanged. The strobe occurs while SCL is low.
- R6: `wr_commit` pulses for exactly one cycle at a STOP that follows one or more accepted data bytes. It does not pulse at any other STOP.
- R7: With `wp_i` high, the device address and the byte address are still acknowledged. The first data byte is not acknowledged, `wr_en` does not pulse, `wr_commit` does not pulse, and the array keeps its contents.
- R8: A read that starts right after START returns the byte at the counter. After each byte sent, the counter holds that byte's address plus one.
- R9: A selective read is a write of the byte address followed by a repeated START with R/W = 1. It returns the byte at that address.
- R10: In a read, a master ACK (SDA low on the 9th clock) makes the slave send the next byte. The counter goes from 8'hFF to 8'h00. A master NACK ends the read, and the slave releases SDA.
- R11: `sda_oe` changes only while SCL is low. The slave releases SDA on the falling SCL edge that ends each acknowledge clock it drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| wp_i | input | 1 | Write protect, 1 blocks programming |
| busy_i | input | 1 | Programming cycle in progress |
| rd_addr | output | 8 | Array read address (address counter) |
| rd_data | input | 8 | Array read data, same cycle |
| wr_en | output | 1 | One-cycle write strobe to the page buffer |
| wr_addr | output | 8 | Address of the forwarded byte |
| wr_data | output | 8 | Forwarded data byte |
| wr_commit | output | 1 | One-cycle pulse that starts programming |

## Verification
Two things happen on the same falling SCL edge: a data byte is forwarded on `wr_en`, and the page-offset counter wraps from offset 15 to 0. The bench provokes this with directed and random page writes that start near a page end and run past 16 bytes. It judges the result from the logged `wr_addr` sequence, which must stay in the page. It then reads the bytes back, and the last write to a repeated offset must win.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_DEV,
    SQ_DEV_ACK,
    SQ_ADR,
    SQ_ADR_ACK,
    SQ_WDAT,
    SQ_WDAT_ACK,
    SQ_RDAT,
    SQ_RDAT_ACK
  } seq_state_e;
endpackage

// File: rtl/i2c_ee_linesync.sv
module i2c_ee_linesync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p, scl_s;

  // Idle bus reads as high on both lines.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q[0] <= scl_i;
      sda_q[0] <= sda_i;
      for (int i = 1; i < STAGES; i++) begin
        scl_q[i] <= scl_q[i-1];
        sda_q[i] <= sda_q[i-1];
      end
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_ee_addrctr.sv
module i2c_ee_addrctr #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [ADDR_W-1:0] ld_val,
  input  logic              inc_seq,
  input  logic              inc_page,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              en;

  always_comb begin
    addr_n = addr_q;
    if (ld)            addr_n = ld_val;
    else if (inc_seq)  addr_n = addr_q + 1'b1;
    else if (inc_page) addr_n = {addr_q[ADDR_W-1:PAGE_W],
                                 PAGE_W'(addr_q[PAGE_W-1:0] + 1'b1)};
  end

  assign en = ld | inc_seq | inc_page;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  addr_q <= '0;
    else if (en) addr_q <= addr_n;
  end

  assign addr = addr_q;
endmodule

// File: rtl/i2c_ee_seq.sv
module i2c_ee_seq
  import i2c_ee_pkg::*;
#(
  parameter int         ADDR_W = 8,
  parameter logic [6:0] DEV_ID = 7'h50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              busy_i,
  input  logic              wp_i,
  input  logic [BYTE_W-1:0] rd_data,
  input  logic [ADDR_W-1:0] addr,
  output logic              sda_oe,
  output logic              ld,
  output logic [ADDR_W-1:0] ld_val,
  output logic              inc_seq,
  output logic              inc_page,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_commit
);
  seq_state_e        st_q, st_n;
  logic [2:0]        cnt_q, cnt_n;
  logic              full_q, full_n, rw_q, rw_n, oe_q, oe_n;
  logic              wrote_q, wrote_n, mack_q, mack_n;
  logic [BYTE_W-1:0] sh_q, sh_n, wrd_q, wrd_n;
  logic [ADDR_W-1:0] wra_q, wra_n;
  logic              wre_q, wre_n, cmt_q, cmt_n;

  always_comb begin
    st_n = st_q;   cnt_n = cnt_q;     full_n = full_q;   sh_n = sh_q;
    rw_n = rw_q;   oe_n = oe_q;       wrote_n = wrote_q; mack_n = mack_q;
    wra_n = wra_q; wrd_n = wrd_q;     wre_n = 1'b0;      cmt_n = 1'b0;
    ld = 1'b0;     inc_seq = 1'b0;    inc_page = 1'b0;
    if (stop_det) begin
      st_n = SQ_IDLE; oe_n = 1'b0; cmt_n = wrote_q; wrote_n = 1'b0;
    end else if (start_det) begin
      st_n = SQ_DEV; cnt_n = '0; full_n = 1'b0; oe_n = 1'b0;
    end else if (scl_rise) begin
      unique case (st_q)
        SQ_DEV, SQ_ADR, SQ_WDAT: begin
          sh_n = {sh_q[BYTE_W-2:0], sda_s}; cnt_n = cnt_q + 1'b1; full_n = (cnt_q == 3'd7);
        end
        SQ_RDAT:     begin cnt_n = cnt_q + 1'b1; full_n = (cnt_q == 3'd7); end
        SQ_RDAT_ACK: mack_n = sda_s;
        default: ;
      endcase
    end else if (scl_fall) begin
      unique case (st_q)
        SQ_DEV: if (full_q) begin
          full_n = 1'b0;
          if (sh_q[7:1] == DEV_ID && !busy_i) begin
            oe_n = 1'b1; rw_n = sh_q[0]; st_n = SQ_DEV_ACK;
          end else st_n = SQ_IDLE;
        end
        SQ_DEV_ACK: if (rw_q) begin
          sh_n = rd_data; oe_n = ~rd_data[7]; inc_seq = 1'b1; st_n = SQ_RDAT;
        end else begin
          oe_n = 1'b0; st_n = SQ_ADR;
        end
        SQ_ADR: if (full_q) begin
          full_n = 1'b0; oe_n = 1'b1; ld = 1'b1; st_n = SQ_ADR_ACK;
        end
        SQ_ADR_ACK: begin oe_n = 1'b0; st_n = SQ_WDAT; end
        SQ_WDAT: if (full_q) begin
          full_n = 1'b0;
          if (wp_i) st_n = SQ_IDLE;
          else begin
            oe_n = 1'b1; wre_n = 1'b1; wra_n = addr; wrd_n = sh_q;
            inc_page = 1'b1; wrote_n = 1'b1; st_n = SQ_WDAT_ACK;
          end
        end
        SQ_WDAT_ACK: begin oe_n = 1'b0; st_n = SQ_WDAT; end
        SQ_RDAT: if (full_q) begin
          full_n = 1'b0; oe_n = 1'b0; st_n = SQ_RDAT_ACK;
        end else begin
          sh_n = {sh_q[BYTE_W-2:0], 1'b0}; oe_n = ~sh_q[6];
        end
        SQ_RDAT_ACK: if (!mack_q) begin
          sh_n = rd_data; oe_n = ~rd_data[7]; inc_seq = 1'b1; st_n = SQ_RDAT;
        end else st_n = SQ_IDLE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE; cnt_q <= '0; full_q <= 1'b0; sh_q <= '0;
      rw_q <= 1'b0; oe_q <= 1'b0; wrote_q <= 1'b0; mack_q <= 1'b1;
      wra_q <= '0; wrd_q <= '0; wre_q <= 1'b0; cmt_q <= 1'b0;
    end else begin
      st_q <= st_n; cnt_q <= cnt_n; full_q <= full_n; sh_q <= sh_n;
      rw_q <= rw_n; oe_q <= oe_n; wrote_q <= wrote_n; mack_q <= mack_n;
      wra_q <= wra_n; wrd_q <= wrd_n; wre_q <= wre_n; cmt_q <= cmt_n;
    end
  end

  assign sda_oe    = oe_q;
  assign ld_val    = sh_q[ADDR_W-1:0];
  assign wr_en     = wre_q;
  assign wr_addr   = wra_q;
  assign wr_data   = wrd_q;
  assign wr_commit = cmt_q;
endmodule

// File: rtl/i2c_ee_slave.sv
module i2c_ee_slave #(
  parameter int         ADDR_W      = 8,
  parameter int         PAGE_W      = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ID      = 7'h50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              wp_i,
  input  logic              busy_i,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_commit
);
  logic [1:0]        rst_q;
  logic              rst_in;
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              ld, inc_seq, inc_page;
  logic [ADDR_W-1:0] ld_val, addr;

  // Reset asserts at once and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_in = rst_q[1];

  i2c_ee_linesync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_in), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_ee_addrctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
    .clk(clk), .rst_n(rst_in), .ld(ld), .ld_val(ld_val),
    .inc_seq(inc_seq), .inc_page(inc_page), .addr(addr)
  );

  i2c_ee_seq #(.ADDR_W(ADDR_W), .DEV_ID(DEV_ID)) u_seq (
    .clk(clk), .rst_n(rst_in), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .busy_i(busy_i), .wp_i(wp_i), .rd_data(rd_data), .addr(addr),
    .sda_oe(sda_oe), .ld(ld), .ld_val(ld_val), .inc_seq(inc_seq),
    .inc_page(inc_page), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_commit(wr_commit)
  );

  assign rd_addr = addr;
endmodule

// File: rtl/i2c_ee_slave_chk.sv
module i2c_ee_slave_chk #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              wp_i,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wr_commit
);
  logic [ADDR_W-PAGE_W-1:0] page_q;
  logic                     open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      open_q <= 1'b0;
    end else if (wr_commit) begin
      open_q <= 1'b0;
    end else if (wr_en) begin
      page_q <= wr_addr[ADDR_W-1:PAGE_W];
      open_q <= 1'b1;
    end
  end

  AST_SDA_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!scl_i && !$past(scl_i))); // R11
  AST_NO_WRITE_PROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !wp_i); // R7
  AST_WRITE_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en); // R5
  AST_WRITE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !scl_i); // R5
  AST_PAGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && open_q) |-> (wr_addr[ADDR_W-1:PAGE_W] == page_q)); // R5
  AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit); // R6
endmodule

bind i2c_ee_slave i2c_ee_slave_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .wp_i(wp_i),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_commit(wr_commit)
);

// File: tb/tb_i2c_ee_slave.sv
module tb_i2c_ee_slave;
  localparam logic [7:0] DEVW = 8'hA0, DEVR = 8'hA1;

  logic clk, rst_n, m_scl, m_low, wp, busy;
  logic sda_bus, sda_oe, wr_en, wr_commit;
  logic [7:0] rd_addr, rd_data, wr_addr, wr_data;
  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];
  logic [7:0] ref_ptr;
  logic [7:0] pbuf [256];
  logic       pval [256];
  logic [7:0] wlog [64];
  int wr_cnt, cmt_cnt, sda_viol, n_chk, n_bad;
  logic prev_oe, prev_scl;

  assign sda_bus = ~(m_low | sda_oe);
  assign rd_data = mem[rd_addr];

  i2c_ee_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .wp_i(wp), .busy_i(busy), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Array and page buffer model, plus a bus monitor, sampled on the falling clock.
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) begin mem[i] = 8'(i) ^ 8'hA5; pval[i] = 1'b0; end
      wr_cnt = 0; cmt_cnt = 0; sda_viol = 0; prev_oe = 1'b0; prev_scl = 1'b1;
    end else begin
      if (wr_en) begin
        pbuf[wr_addr] = wr_data; pval[wr_addr] = 1'b1;
        wlog[wr_cnt % 64] = wr_addr; wr_cnt++;
      end
      if (wr_commit) begin
        cmt_cnt++;
        for (int i = 0; i < 256; i++) if (pval[i]) begin mem[i] = pbuf[i]; pval[i] = 1'b0; end
      end
      if (sda_oe !== prev_oe && (m_scl || prev_scl)) sda_viol++;
      prev_oe = sda_oe; prev_scl = m_scl;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (6) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_low = 1'b0; wq(); m_scl = 1'b1; wq(); m_low = 1'b1; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    m_low = 1'b1; wq(); m_scl = 1'b1; wq(); m_low = 1'b0; wq();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_low = ~b[i]; wq(); m_scl = 1'b1; wq(); m_scl = 1'b0; wq();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    m_low = 1'b0; wq(); m_scl = 1'b1; wq(); ack = ~sda_bus; m_scl = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 0; i < 8; i++) begin
      wq(); m_scl = 1'b1; wq(); b = {b[6:0], sda_bus}; m_scl = 1'b0;
    end
    wq(); m_low = mack; wq(); m_scl = 1'b1; wq(); m_scl = 1'b0; wq(); m_low = 1'b0;
  endtask

  function automatic logic [7:0] page_step(input logic [7:0] a, input int k);
    return {a[7:4], 4'(a[3:0] + k[3:0])};
  endfunction

  task automatic read_run(input int n, input string req);
    logic [7:0] d;
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, d);
      chk(req, d, ref_mem[ref_ptr]);
      ref_ptr = ref_ptr + 8'd1;
    end
  endtask

  task automatic read_cur(input int n, input string req);
    logic ack;
    i2c_start(); send_byte(DEVR, ack); chk("R2 read address ack", ack, 1);
    read_run(n, req); i2c_stop();
  endtask

  task automatic read_sel(input logic [7:0] a, input int n, input string req);
    logic ack;
    i2c_start(); send_byte(DEVW, ack); chk("R9 dummy write ack", ack, 1);
    send_byte(a, ack); chk("R4 byte address ack", ack, 1);
    i2c_start(); send_byte(DEVR, ack); chk("R9 read after repeated START ack", ack, 1);
    ref_ptr = a; read_run(n, req); i2c_stop();
  endtask

  task automatic write_page(input logic [7:0] a, input int n);
    logic ack; logic [7:0] d; int w0, c0;
    w0 = wr_cnt; c0 = cmt_cnt;
    i2c_start(); send_byte(DEVW, ack); chk("R2 write address ack", ack, 1);
    send_byte(a, ack); chk("R4 byte address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      send_byte(d, ack); chk("R5 data ack", ack, 1);
      ref_mem[page_step(a, k)] = d;
    end
    i2c_stop();
    ref_ptr = page_step(a, n);
    chk("R5 strobe count", wr_cnt - w0, n);
    for (int k = 0; k < n; k++) chk("R5 page address", wlog[(w0 + k) % 64], page_step(a, k));
    chk("R6 one commit", cmt_cnt - c0, 1);
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    repeat (190000) @(posedge clk);
    chk("watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic ack; logic [7:0] d; int w0, c0;
    void'($urandom(32'd20240611));
    m_scl = 1'b1; m_low = 1'b0; wp = 1'b0; busy = 1'b0; rst_n = 1'b0;
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'(i) ^ 8'hA5;
    ref_ptr = 8'h00;
    repeat (5) @(negedge clk);
    chk("R1 reset sda_oe", sda_oe, 0);
    chk("R1 reset wr_en", wr_en, 0);
    chk("R1 reset wr_commit", wr_commit, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // Counter after reset, then a page write that wraps at the page end.
    read_cur(2, "R8 current read after reset");
    write_page(8'h3C, 6);
    read_cur(3, "R8 current read after write");

    // Selective read that crosses the top of the array.
    read_sel(8'hFE, 4, "R10 sequential wrap to 0");
    read_cur(1, "R8 counter continues after NACK");

    // Foreign device address: no ack and the following bytes are ignored.
    w0 = wr_cnt; c0 = cmt_cnt;
    i2c_start(); send_byte(8'hA4, ack); chk("R2 foreign address nack", ack, 0);
    send_byte(8'h10, ack); chk("R2 later byte ignored", ack, 0);
    send_byte(8'h77, ack); chk("R2 later byte ignored", ack, 0);
    i2c_stop();
    chk("R2 no strobe", wr_cnt - w0, 0);
    chk("R6 no commit without data", cmt_cnt - c0, 0);
    read_cur(1, "R2 counter untouched");

    // Write protect.
    wp = 1'b1;
    i2c_start(); send_byte(DEVW, ack); chk("R7 device address ack", ack, 1);
    send_byte(8'h55, ack); chk("R7 byte address ack", ack, 1);
    send_byte(8'h0F, ack); chk("R7 data nack", ack, 0);
    i2c_stop();
    wp = 1'b0;
    chk("R7 no strobe", wr_cnt - w0, 0);
    chk("R7 no commit", cmt_cnt - c0, 0);
    read_sel(8'h55, 1, "R7 array unchanged");

    // Busy polling.
    busy = 1'b1;
    i2c_start(); send_byte(DEVW, ack); chk("R3 busy write nack", ack, 0); i2c_stop();
    i2c_start(); send_byte(DEVR, ack); chk("R3 busy read nack", ack, 0); i2c_stop();
    busy = 1'b0;
    i2c_start(); send_byte(DEVW, ack); chk("R3 ack after busy", ack, 1); i2c_stop();
    chk("R6 no commit on address-only STOP", cmt_cnt - c0, 0);

    // START in the middle of a byte restarts reception.
    i2c_start(); send_bits(8'hFF, 4);
    i2c_start(); send_byte(DEVR, ack); chk("R1 restart mid-byte ack", ack, 1);
    read_run(1, "R1 read after restart"); i2c_stop();

    // Random page writes and read-back mixed in.
    for (int t = 0; t < 10; t++) begin
      write_page(8'($urandom), 1 + int'($urandom % 19));
      read_sel(8'($urandom), 1 + int'($urandom % 6), "R9 random selective read");
      read_cur(2, "R8 random current read");
    end

    // Page wrap beyond 16 bytes: last write wins.
    write_page(8'h7E, 18);
    read_sel(8'h70, 16, "R5 page contents after overrun");

    chk("R11 sda_oe stable while SCL high", sda_viol, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule